// File: doc/BRIEF.md
# BCD Alarm Match Unit

This block decides when a running clock-calendar has reached a programmed alarm moment. It receives the current time and date as packed BCD words from counters that live elsewhere, holds one time alarm word and one date alarm word written through two load ports, and raises a one-cycle pulse when every enabled alarm field agrees with the current value.

Each field (seconds, minutes, hours, month, day of month) carries its own enable, so an alarm can fire once a minute or once a year, depending on which fields are enabled. The hour comparison follows a mode input: in 12-hour mode the AM/PM bit takes part and hours run 01 to 12, while in 24-hour mode the AM/PM bit is ignored and hours run 00 to 23. Enabled fields that hold malformed BCD or an out-of-range value are reported on two validity outputs, one per alarm word. Either report blocks the alarm.

The pulse marks only the start of a match. A match that lasts for many cycles, such as one on minutes alone, produces one pulse.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: The time alarm word is stored on a rising clock edge where `tal_wr_i` is 1 and is left unchanged while it is 0. Its layout is seconds at [6:0] with enable [7], minutes at [14:8] with enable [15], hours at [21:16], PM flag [22] and hour enable [23].
- R2: The date alarm word is stored on a rising clock edge where `dal_wr_i` is 1. Its layout is month at [20:16] with enable [23] and day of month at [29:24] with enable [31].
- R3: `now_time_i` carries seconds, minutes, hours and the PM flag at the same bit positions as the time alarm word. `now_date_i` carries month at [20:16] and day of month at [29:24].
- R4: `alarm_rise_o` is high for exactly one cycle, one clock edge after the first cycle in which all of the following hold: every enabled field equals its current value, at least one field is enabled, and neither entry is non-valid.
- R5: A field whose enable bit is 0 plays no part in the match or in the validity check. With no field enabled, no pulse is produced.
- R6: With `mode12_i` = 1, the PM flag must also match, and valid alarm hours are BCD 01 to 12. With `mode12_i` = 0, the PM flag is ignored, and valid hours are 00 to 23.
- R7: While a match persists there is no further pulse. A new pulse needs at least one cycle without a match first.
- R8: `tal_bad_o` is 1 when an enabled seconds or minutes field has a units digit above 9 or a value above 59, or when an enabled hour is outside the range for the current mode.
- R9: `dal_bad_o` is 1 when an enabled month has a units digit above 9 or lies outside 01 to 12, or when an enabled day of month has a units digit above 9 or lies outside 01 to 31.
- R10: While either `tal_bad_o` or `dal_bad_o` is 1, no pulse is produced, even when every enabled field matches.
- R11: Reset clears both alarm words to all-disabled and holds `alarm_rise_o` at 0. After reset is released, no pulse occurs until an alarm is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode12_i | input | 1 | 1 selects 12-hour mode, 0 selects 24-hour mode |
| now_time_i | input | 32 | Current BCD time word |
| now_date_i | input | 32 | Current BCD date word |
| tal_wr_i | input | 1 | Load strobe for the time alarm word |
| tal_data_i | input | 32 | Time alarm word to load |
| dal_wr_i | input | 1 | Load strobe for the date alarm word |
| dal_data_i | input | 32 | Date alarm word to load |
| alarm_rise_o | output | 1 | One-cycle pulse at the start of a match |
| tal_bad_o | output | 1 | Stored time alarm entry is non-valid |
| dal_bad_o | output | 1 | Stored date alarm entry is non-valid |

## Verification
There are three internal states, and each shows up at the ports one edge after it goes wrong:
- **Stored alarm word:** a corrupted word shows on the validity outputs in the cycle after the load.
- **Pulse:** the next applied time either fails to pulse or pulses when it should not.
- **Match history:** a wrong history register gives either a missing first pulse or a second pulse on the following edge of a held match. The held-match and drop-and-return sequences therefore watch every cycle.

Hour handling is tested with the same stored word under both modes, because that is where a mode-dependent mistake would appear.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int WORD_W   = 32;
  localparam int SEC_LSB  = 0;
  localparam int SEC_W    = 7;
  localparam int SEC_EN   = 7;
  localparam int MIN_LSB  = 8;
  localparam int MIN_W    = 7;
  localparam int MIN_EN   = 15;
  localparam int HR_LSB   = 16;
  localparam int HR_W     = 6;
  localparam int PM_BIT   = 22;
  localparam int HR_EN    = 23;
  localparam int MON_LSB  = 16;
  localparam int MON_W    = 5;
  localparam int MON_EN   = 23;
  localparam int DAY_LSB  = 24;
  localparam int DAY_W    = 6;
  localparam int DAY_EN   = 31;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/alarm_word_reg.sv
module alarm_word_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (we_i) word_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign q_o = word_q;

  // R1 / R2: a strobed word is what is held one edge later
  a_r1_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(d_i)));
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/bcd_field_chk.sv
module bcd_field_chk #(
  parameter int W  = 7,
  parameter int LO = 0,
  parameter int HI = 59
) (
  input  logic [W-1:0] val_i,
  output logic         ok_o
);
  localparam int TW = W - 4;
  logic [3:0]    units;
  logic [TW-1:0] tens;
  int            dec;

  always_comb begin
    units = val_i[3:0];
    tens  = val_i[W-1:4];
    dec   = int'(tens) * 10 + int'(units);
    ok_o  = (units <= 4'd9) && (dec >= LO) && (dec <= HI);
  end
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import bcd_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode12_i,
  input  logic [WORD_W-1:0] now_time_i,
  input  logic [WORD_W-1:0] now_date_i,
  input  logic              tal_wr_i,
  input  logic [WORD_W-1:0] tal_data_i,
  input  logic              dal_wr_i,
  input  logic [WORD_W-1:0] dal_data_i,
  output logic              alarm_rise_o,
  output logic              tal_bad_o,
  output logic              dal_bad_o
);
  logic              rst_n_s;
  logic [WORD_W-1:0] tal_q, dal_q;

  rst_sync #(.STAGES(2)) u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n_s));

  alarm_word_reg #(.W(WORD_W)) u_tal (
    .clk_i(clk_i), .rst_ni(rst_n_s), .we_i(tal_wr_i), .d_i(tal_data_i), .q_o(tal_q));
  alarm_word_reg #(.W(WORD_W)) u_dal (
    .clk_i(clk_i), .rst_ni(rst_n_s), .we_i(dal_wr_i), .d_i(dal_data_i), .q_o(dal_q));

  // field views of the stored alarm and the current value
  logic [SEC_W-1:0] a_sec, n_sec;
  logic [MIN_W-1:0] a_min, n_min;
  logic [HR_W-1:0]  a_hr,  n_hr;
  logic [MON_W-1:0] a_mon, n_mon;
  logic [DAY_W-1:0] a_day, n_day;
  logic a_pm, n_pm;
  logic en_sec, en_min, en_hr, en_mon, en_day;

  always_comb begin
    a_sec  = tal_q[SEC_LSB +: SEC_W];
    a_min  = tal_q[MIN_LSB +: MIN_W];
    a_hr   = tal_q[HR_LSB  +: HR_W];
    a_pm   = tal_q[PM_BIT];
    a_mon  = dal_q[MON_LSB +: MON_W];
    a_day  = dal_q[DAY_LSB +: DAY_W];
    en_sec = tal_q[SEC_EN];
    en_min = tal_q[MIN_EN];
    en_hr  = tal_q[HR_EN];
    en_mon = dal_q[MON_EN];
    en_day = dal_q[DAY_EN];
    n_sec  = now_time_i[SEC_LSB +: SEC_W];
    n_min  = now_time_i[MIN_LSB +: MIN_W];
    n_hr   = now_time_i[HR_LSB  +: HR_W];
    n_pm   = now_time_i[PM_BIT];
    n_mon  = now_date_i[MON_LSB +: MON_W];
    n_day  = now_date_i[DAY_LSB +: DAY_W];
  end

  logic unused_bits;
  assign unused_bits = ^{tal_q[WORD_W-1:HR_EN+1], dal_q[MON_LSB-1:0],
                         dal_q[MON_EN-1:MON_LSB+MON_W], dal_q[DAY_EN-1:DAY_LSB+DAY_W],
                         now_time_i[WORD_W-1:PM_BIT+1], now_time_i[SEC_EN], now_time_i[MIN_EN],
                         now_date_i[MON_LSB-1:0], now_date_i[MON_EN:MON_LSB+MON_W],
                         now_date_i[WORD_W-1:DAY_LSB+DAY_W]};

  // range / digit checks on the stored entry
  logic ok_sec, ok_min, ok_h12, ok_h24, ok_mon, ok_day, ok_hr;

  bcd_field_chk #(.W(SEC_W), .LO(0), .HI(59)) u_ck_sec (.val_i(a_sec), .ok_o(ok_sec));
  bcd_field_chk #(.W(MIN_W), .LO(0), .HI(59)) u_ck_min (.val_i(a_min), .ok_o(ok_min));
  bcd_field_chk #(.W(HR_W),  .LO(1), .HI(12)) u_ck_h12 (.val_i(a_hr),  .ok_o(ok_h12));
  bcd_field_chk #(.W(HR_W),  .LO(0), .HI(23)) u_ck_h24 (.val_i(a_hr),  .ok_o(ok_h24));
  bcd_field_chk #(.W(MON_W), .LO(1), .HI(12)) u_ck_mon (.val_i(a_mon), .ok_o(ok_mon));
  bcd_field_chk #(.W(DAY_W), .LO(1), .HI(31)) u_ck_day (.val_i(a_day), .ok_o(ok_day));

  always_comb begin
    ok_hr     = mode12_i ? ok_h12 : ok_h24;
    tal_bad_o = (en_sec & ~ok_sec) | (en_min & ~ok_min) | (en_hr & ~ok_hr);
    dal_bad_o = (en_mon & ~ok_mon) | (en_day & ~ok_day);
  end

  // per-field match, then the combined condition
  logic hit_sec, hit_min, hit_hr, hit_mon, hit_day, any_en, match_c;

  always_comb begin
    hit_sec = ~en_sec | (a_sec == n_sec);
    hit_min = ~en_min | (a_min == n_min);
    hit_hr  = ~en_hr  | ((a_hr == n_hr) & (~mode12_i | (a_pm == n_pm)));
    hit_mon = ~en_mon | (a_mon == n_mon);
    hit_day = ~en_day | (a_day == n_day);
    any_en  = en_sec | en_min | en_hr | en_mon | en_day;
    match_c = any_en & ~tal_bad_o & ~dal_bad_o &
              hit_sec & hit_min & hit_hr & hit_mon & hit_day;
  end

  // edge detection on the match
  logic match_q, match_d, rise_q, rise_d;

  always_comb begin
    match_d = match_c;
    rise_d  = match_c & ~match_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      match_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      match_q <= match_d;
      rise_q  <= rise_d;
    end
  end

  assign alarm_rise_o = rise_q;

  // R7: never two pulses back to back
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    alarm_rise_o |=> !alarm_rise_o);
  // R4: a pulse always coincides with a recorded match
  a_r4_pulse_has_match: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    alarm_rise_o |-> match_q);
  // R10: a non-valid entry keeps the output quiet
  a_r10_bad_blocks: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (tal_bad_o || dal_bad_o) |=> !alarm_rise_o);
  // R5: nothing enabled, nothing fires
  a_r5_no_enable: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !(tal_q[SEC_EN] | tal_q[MIN_EN] | tal_q[HR_EN] | dal_q[MON_EN] | dal_q[DAY_EN])
      |=> !alarm_rise_o);
endmodule

// File: tb/sim_bcd_alarm_cmp.sv
module sim_bcd_alarm_cmp;
  localparam int CLK_P = 10;
  localparam logic [31:0] IDLE_T = 32'h007F_7F7F;
  localparam logic [31:0] IDLE_D = 32'h3F1F_0000;

  typedef struct packed {
    logic        mode;
    logic [31:0] tal;
    logic [31:0] dal;
    logic [31:0] tm;
    logic [31:0] dt;
    logic        rise;
    logic        tb;
    logic        db;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0000_00B0, 32'h0,         32'h0010_2530, 32'h1506_0000, 1'b1, 1'b0, 1'b0}, // R4 sec only
    '{1'b0, 32'h0000_00B0, 32'h0,         32'h0010_2531, 32'h1506_0000, 1'b0, 1'b0, 1'b0}, // R4 miss
    '{1'b0, 32'h00A3_D980, 32'h0,         32'h0023_5900, 32'h0,         1'b1, 1'b0, 1'b0}, // R3 full time
    '{1'b0, 32'h00C8_0000, 32'h0,         32'h0008_1111, 32'h0,         1'b1, 1'b0, 1'b0}, // R6 pm ignored
    '{1'b1, 32'h00C8_0000, 32'h0,         32'h0008_1111, 32'h0,         1'b0, 1'b0, 1'b0}, // R6 pm differs
    '{1'b1, 32'h00C8_0000, 32'h0,         32'h0048_1111, 32'h0,         1'b1, 1'b0, 1'b0}, // R6 pm equal
    '{1'b1, 32'h0080_0000, 32'h0,         32'h0000_0000, 32'h0,         1'b0, 1'b1, 1'b0}, // R6 hour 00 in 12h
    '{1'b0, 32'h0080_0000, 32'h0,         32'h0000_0000, 32'h0,         1'b1, 1'b0, 1'b0}, // R6 hour 00 in 24h
    '{1'b0, 32'h00A4_0000, 32'h0,         32'h0024_0000, 32'h0,         1'b0, 1'b1, 1'b0}, // R8 hour 24
    '{1'b1, 32'h0093_0000, 32'h0,         32'h0013_0000, 32'h0,         1'b0, 1'b1, 1'b0}, // R8 hour 13 in 12h
    '{1'b0, 32'h0000_00E0, 32'h0,         32'h0000_0060, 32'h0,         1'b0, 1'b1, 1'b0}, // R8 sec 60
    '{1'b0, 32'h0000_9A00, 32'h0,         32'h0000_1A00, 32'h0,         1'b0, 1'b1, 1'b0}, // R8 min digit A
    '{1'b0, 32'h0000_857F, 32'h0,         32'h0000_0500, 32'h0,         1'b1, 1'b0, 1'b0}, // R5 disabled junk
    '{1'b0, 32'h0,         32'hB192_0000, 32'h0,         32'h3112_0000, 1'b1, 1'b0, 1'b0}, // R2 date match
    '{1'b0, 32'h0,         32'h0093_0000, 32'h0,         32'h0013_0000, 1'b0, 1'b0, 1'b1}, // R9 month 13
    '{1'b0, 32'h0,         32'h0080_0000, 32'h0,         32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R9 month 00
    '{1'b0, 32'h0,         32'hB200_0000, 32'h0,         32'h3200_0000, 1'b0, 1'b0, 1'b1}, // R9 day 32
    '{1'b0, 32'h0,         32'h8000_0000, 32'h0,         32'h0000_0000, 1'b0, 1'b0, 1'b1}, // R9 day 00
    '{1'b0, 32'h0,         32'h8B00_0000, 32'h0,         32'h0B00_0000, 1'b0, 1'b0, 1'b1}, // R9 day digit B
    '{1'b0, 32'h0000_00B0, 32'h0093_0000, 32'h0000_0030, 32'h0013_0000, 1'b0, 1'b0, 1'b1}, // R10 bad date
    '{1'b0, 32'h0000_00B0, 32'h9500_0000, 32'h0000_0030, 32'h1600_0000, 1'b0, 1'b0, 1'b0}, // R4 date miss
    '{1'b0, 32'h0,         32'h0,         32'h0000_0000, 32'h0,         1'b0, 1'b0, 1'b0}  // R5 none enabled
  };

  logic clk = 1'b0;
  logic rst_n, mode12, tal_wr, dal_wr;
  logic [31:0] now_t, now_d, tal_d, dal_d;
  logic rise, tbad, dbad;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  bcd_alarm_cmp u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode12_i(mode12), .now_time_i(now_t), .now_date_i(now_d),
    .tal_wr_i(tal_wr), .tal_data_i(tal_d), .dal_wr_i(dal_wr), .dal_data_i(dal_d),
    .alarm_rise_o(rise), .tal_bad_o(tbad), .dal_bad_o(dbad));

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(input logic m, input logic [31:0] t, input logic [31:0] d);
    @(negedge clk);
    mode12 = m; tal_wr = 1'b1; tal_d = t; dal_wr = 1'b1; dal_d = d;
    now_t = IDLE_T; now_d = IDLE_D;
    @(negedge clk);
    tal_wr = 1'b0; dal_wr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode12 = 1'b0; tal_wr = 1'b0; dal_wr = 1'b0;
    tal_d = '0; dal_d = '0; now_t = '0; now_d = '0;
    repeat (3) @(negedge clk);
    chk("R11 rise in reset", rise, 1'b0);
    chk("R11 tbad in reset", tbad, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 no pulse after reset", rise, 1'b0);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i].mode, VEC[i].tal, VEC[i].dal);
      now_t = VEC[i].tm; now_d = VEC[i].dt;
      #1;
      chk($sformatf("R8 tbad vec %0d", i), tbad, VEC[i].tb);
      chk($sformatf("R9 dbad vec %0d", i), dbad, VEC[i].db);
      @(negedge clk);
      chk($sformatf("R4 rise vec %0d", i), rise, VEC[i].rise);
      @(negedge clk);
      chk($sformatf("R7 one pulse vec %0d", i), rise, 1'b0);
    end

    // R7: held match, then drop and return
    load(1'b0, 32'h0000_8500, 32'h0);
    now_t = 32'h0000_0512;
    @(negedge clk);
    chk("R7 first pulse", rise, 1'b1);
    for (int k = 0; k < 5; k++) begin
      now_t = 32'h0000_0500 + 32'(k);
      @(negedge clk);
      chk("R7 held match quiet", rise, 1'b0);
    end
    now_t = 32'h0000_0600;
    @(negedge clk);
    chk("R7 no match quiet", rise, 1'b0);
    now_t = 32'h0000_0500;
    @(negedge clk);
    chk("R7 second pulse", rise, 1'b1);

    // R1: data without strobe is ignored
    load(1'b0, 32'h0000_00B0, 32'h0);
    tal_d = 32'h0000_00B1;
    now_t = 32'h0000_0030;
    @(negedge clk);
    chk("R1 old word still matches", rise, 1'b1);
    now_t = IDLE_T;
    @(negedge clk);
    now_t = 32'h0000_0031;
    @(negedge clk);
    chk("R1 unstrobed word not used", rise, 1'b0);

    // R6: mode switch with a stored hour 00 alarm
    load(1'b0, 32'h0080_0000, 32'h0);
    #1;
    chk("R6 hour 00 valid 24h", tbad, 1'b0);
    mode12 = 1'b1;
    #1;
    chk("R6 hour 00 bad 12h", tbad, 1'b1);

    // R11: reset wipes a stored alarm
    load(1'b0, 32'h0000_00B0, 32'hB192_0000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    now_t = 32'h0000_0030; now_d = 32'h3112_0000;
    @(negedge clk);
    chk("R11 cleared alarm silent", rise, 1'b0);
    chk("R11 dbad clear", dbad, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule